// File: doc/BRIEF.md
# DMA Bus-Mode Transfer Sequencer

This block decides when a small multi-channel DMA engine owns the system bus and which channel it serves. Each channel is armed by a one-clock start pulse. The pulse captures four things: a transfer count, a burst preference, an activation source and a transfer unit. The activation source is either an automatic request or an active-low external request line. The transfer unit is a byte, a word or a block. The block raises a bus request to the CPU arbiter and waits for the grant. It then runs fixed-length bus cycles for one unit at a time and strobes once at the end of each unit.

In cycle-steal operation the bus is handed back after every unit. A one-cycle idle gap always separates successive DMA ownerships, even when no other master wants the bus. The bus is reacquired while a request is still pending. A channel that is triggered by its external line always uses cycle steal, whatever its burst setting.

A channel that is automatically triggered and configured for burst keeps the bus across units until its count runs out. It gives the bus up early only when another channel becomes pending, and only at a unit boundary. At every release point the lowest-numbered pending channel wins. When a channel moves its last unit, it raises a one-clock done pulse and stops requesting.

Top module: `bus_mode_seq`

## Requirements
- R1: After reset, busReq, busCycle, unitStrobe, every extAck bit and every chDone bit are low.
- R2: A chStart pulse arms a channel with chCount and its settings. A start with a count of zero is ignored. A start for a channel that is already armed is ignored and does not change its remaining count.
- R3: busReq stays high until busGrant is seen. No bus cycle (busCycle high) occurs before a grant.
- R4: A unit takes 1 bus cycle for chUnit=00 (byte), 2 for 01 (word), and BLOCK_CYC for 10 or 11 (block). unitStrobe is high in the last bus cycle of each unit, with unitCh giving the channel. An armed channel gets exactly chCount strobes.
- R5: In cycle-steal operation busReq drops after every unit. It stays low for exactly one cycle and rises again if a channel is still pending.
- R6: An automatically triggered channel with chBurst=1 keeps busReq high across all of its units when no other channel is pending, so it uses a single ownership.
- R7: A channel with chExtSrc=1 runs in cycle steal even when chBurst=1. It is pending only while its extReqN bit is low, and while that bit is high it causes no bus request.
- R8: A burst transfer gives up the bus at the next unit boundary when another channel becomes pending, and it resumes later to finish its count.
- R9: When several channels are pending at a release point, the lowest-numbered one is served.
- R10: extAck bit i is high in exactly the bus cycles of units moved for channel i when that channel is externally triggered, and it is low at all other times.
- R11: chDone bit i pulses for one clock, in the cycle after the final unitStrobe of channel i. The channel then stops requesting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chStart | input | NUM_CH | One-clock arm pulse per channel |
| chCount | input | NUM_CH*CNT_W | Unit count per channel, captured at start |
| chBurst | input | NUM_CH | Burst preference per channel |
| chExtSrc | input | NUM_CH | 1 = external request line, 0 = automatic |
| chUnit | input | NUM_CH*2 | Unit size per channel: 00 byte, 01 word, 1x block |
| extReqN | input | NUM_CH | Active-low external request levels |
| busReq | output | 1 | Bus request to the arbiter |
| busGrant | input | 1 | Bus grant from the arbiter |
| busCycle | output | 1 | DMA bus cycle in progress |
| unitStrobe | output | 1 | Last bus cycle of a unit |
| unitCh | output | max(1,clog2(NUM_CH)) | Channel owning the current bus cycle or strobe |
| extAck | output | NUM_CH | Acknowledge for externally triggered transfers |
| chDone | output | NUM_CH | One-clock completion pulse per channel |

## Verification
The hardest case to reach is a burst that is preempted part way through. It only happens if a second channel becomes pending while the first one is between its first and last unit. To get there, the stimulus arms a long byte-unit burst and waits until at least two of its strobes have been seen. It then arms a higher-priority channel, and checks three things: the strobe order shows the intruder between burst units, the request rises exactly three times, and the burst still completes its full count. Withholding the grant and holding an external line inactive are the other two states that are reachable only by shaping the stimulus.

// File: rtl/dms_pkg.sv
package dms_pkg;
  localparam int SEL_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_XFER,
    ST_GAP
  } seq_state_e;

  typedef struct packed {
    logic             decEn;
    logic [SEL_W-1:0] sel;
  } seq_ctl_t;
endpackage

// File: rtl/dms_chan_bank.sv
module dms_chan_bank
  import dms_pkg::*;
#(
  parameter int NCH       = 4,
  parameter int CNT_W     = 8,
  parameter int BLOCK_CYC = 4,
  parameter int CYC_W     = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NCH-1:0]     chStart,
  input  logic [NCH*CNT_W-1:0] chCount,
  input  logic [NCH-1:0]     chBurst,
  input  logic [NCH-1:0]     chExtSrc,
  input  logic [NCH*2-1:0]   chUnit,
  input  logic [NCH-1:0]     extReqN,
  input  seq_ctl_t           ctl,
  output logic [NCH-1:0]     pending,
  output logic [CYC_W-1:0]   curLen,
  output logic               curSteal,
  output logic               curExt,
  output logic               curLast,
  output logic [NCH-1:0]     chDone
);

  logic [NCH-1:0]   activeV;
  logic [NCH-1:0]   stealV;
  logic [NCH-1:0]   extV;
  logic [NCH-1:0]   lastV;
  logic [CYC_W-1:0] lenV [NCH];
  logic             selActive;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic             actQ;
    logic             burstQ;
    logic             extQ;
    logic             doneQ;
    logic [1:0]       unitQ;
    logic [CNT_W-1:0] cntQ;
    logic             hit;
    logic [CNT_W-1:0] startCnt;

    assign hit      = ctl.decEn && (ctl.sel == SEL_W'(g));
    assign startCnt = chCount[g*CNT_W +: CNT_W];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        actQ   <= 1'b0;
        burstQ <= 1'b0;
        extQ   <= 1'b0;
        doneQ  <= 1'b0;
        unitQ  <= 2'b00;
        cntQ   <= '0;
      end else begin
        doneQ <= 1'b0;
        if (hit && actQ) begin
          cntQ <= cntQ - CNT_W'(1);
          if (cntQ == CNT_W'(1)) begin
            actQ  <= 1'b0;
            doneQ <= 1'b1;
          end
        end else if (chStart[g] && !actQ && (startCnt != '0)) begin
          actQ   <= 1'b1;
          cntQ   <= startCnt;
          burstQ <= chBurst[g];
          extQ   <= chExtSrc[g];
          unitQ  <= chUnit[g*2 +: 2];
        end
      end
    end

    assign activeV[g] = actQ;
    assign pending[g] = actQ && (!extQ || !extReqN[g]);
    assign stealV[g]  = extQ || !burstQ;
    assign extV[g]    = extQ;
    assign lastV[g]   = (cntQ == CNT_W'(1));
    assign chDone[g]  = doneQ;
    assign lenV[g]    = (unitQ == 2'b00) ? CYC_W'(1) :
                        (unitQ == 2'b01) ? CYC_W'(2) : CYC_W'(BLOCK_CYC);
  end

  always_comb begin
    curLen    = CYC_W'(1);
    curSteal  = 1'b1;
    curExt    = 1'b0;
    curLast   = 1'b0;
    selActive = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (ctl.sel == SEL_W'(i)) begin
        curLen    = lenV[i];
        curSteal  = stealV[i];
        curExt    = extV[i];
        curLast   = lastV[i];
        selActive = activeV[i];
      end
    end
  end

  // R11
  done_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chDone));

  // R2
  dec_armed_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.decEn |-> selActive);

endmodule

// File: rtl/dms_bus_ctl.sv
module dms_bus_ctl
  import dms_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int CYC_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NCH-1:0]   pending,
  input  logic [CYC_W-1:0] curLen,
  input  logic             curSteal,
  input  logic             curExt,
  input  logic             curLast,
  input  logic             busGrant,
  output seq_ctl_t         ctl,
  output logic             busReq,
  output logic             busCycle,
  output logic             unitStrobe,
  output logic [NCH-1:0]   extAck
);

  seq_state_e       state;
  logic [CYC_W-1:0] cyc;
  logic [SEL_W-1:0] curCh;
  logic [SEL_W-1:0] winCh;
  logic             anyPend;
  logic             otherPend;
  logic             unitEnd;

  always_comb begin
    winCh   = '0;
    anyPend = |pending;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pending[i]) winCh = SEL_W'(i);
    end
  end

  always_comb begin
    otherPend = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (pending[i] && (curCh != SEL_W'(i))) otherPend = 1'b1;
    end
  end

  assign unitEnd = (state == ST_XFER) && (cyc == curLen - CYC_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cyc   <= '0;
      curCh <= '0;
    end else begin
      case (state)
        ST_IDLE, ST_GAP: begin
          if (anyPend) begin
            state <= ST_REQ;
            curCh <= winCh;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_REQ: begin
          if (busGrant) begin
            state <= ST_XFER;
            cyc   <= '0;
          end
        end
        ST_XFER: begin
          if (unitEnd) begin
            if (!curSteal && !curLast && !otherPend) begin
              cyc <= '0;
            end else begin
              state <= ST_GAP;
            end
          end else begin
            cyc <= cyc + CYC_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busReq     = (state == ST_REQ) || (state == ST_XFER);
  assign busCycle   = (state == ST_XFER);
  assign unitStrobe = unitEnd;
  assign ctl.decEn  = unitEnd;
  assign ctl.sel    = curCh;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      extAck[i] = busCycle && curExt && (curCh == SEL_W'(i));
    end
  end

  // R5
  steal_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (unitStrobe && curSteal) |=> !busReq);

  // R5
  release_at_unit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busReq) |-> $past(unitStrobe));

  // R3
  grant_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busCycle) |-> $past(busGrant));

  // R10
  ack_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(extAck));

endmodule

// File: rtl/bus_mode_seq.sv
module bus_mode_seq
  import dms_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int CNT_W     = 8,
  parameter int BLOCK_CYC = 4,
  localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int CYC_W    = $clog2(BLOCK_CYC + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_CH-1:0]     chStart,
  input  logic [NUM_CH*CNT_W-1:0] chCount,
  input  logic [NUM_CH-1:0]     chBurst,
  input  logic [NUM_CH-1:0]     chExtSrc,
  input  logic [NUM_CH*2-1:0]   chUnit,
  input  logic [NUM_CH-1:0]     extReqN,
  output logic                  busReq,
  input  logic                  busGrant,
  output logic                  busCycle,
  output logic                  unitStrobe,
  output logic [CH_W-1:0]       unitCh,
  output logic [NUM_CH-1:0]     extAck,
  output logic [NUM_CH-1:0]     chDone
);

  seq_ctl_t          ctl;
  logic [NUM_CH-1:0] pending;
  logic [CYC_W-1:0]  curLen;
  logic              curSteal;
  logic              curExt;
  logic              curLast;

  dms_chan_bank #(
    .NCH(NUM_CH), .CNT_W(CNT_W), .BLOCK_CYC(BLOCK_CYC), .CYC_W(CYC_W)
  ) bank (
    .clk(clk), .rstN(rstN), .chStart(chStart), .chCount(chCount),
    .chBurst(chBurst), .chExtSrc(chExtSrc), .chUnit(chUnit),
    .extReqN(extReqN), .ctl(ctl), .pending(pending), .curLen(curLen),
    .curSteal(curSteal), .curExt(curExt), .curLast(curLast),
    .chDone(chDone)
  );

  dms_bus_ctl #(.NCH(NUM_CH), .CYC_W(CYC_W)) ctrl (
    .clk(clk), .rstN(rstN), .pending(pending), .curLen(curLen),
    .curSteal(curSteal), .curExt(curExt), .curLast(curLast),
    .busGrant(busGrant), .ctl(ctl), .busReq(busReq), .busCycle(busCycle),
    .unitStrobe(unitStrobe), .extAck(extAck)
  );

  assign unitCh = ctl.sel[CH_W-1:0];

endmodule

// File: tb/bus_mode_seq_test.sv
module bus_mode_seq_test;
  localparam int CLK_P = 10;
  localparam int NCH   = 4;
  localparam int CW    = 8;
  localparam int NV    = 6;
  // {burst, ext, unit[1:0], count[3:0], expRises[3:0], expBusCycles[3:0]}
  localparam logic [15:0] VEC [NV] = '{16'h0333, 16'h8414, 16'h9316,
                                       16'h2228, 16'hC333, 16'h5224};

  logic clk = 0;
  logic rstN = 0;
  logic [NCH-1:0] chStart = '0, chBurst = '0, chExtSrc = '0, extReqN = '1;
  logic [NCH*CW-1:0] chCount = '0;
  logic [NCH*2-1:0] chUnit = '0;
  logic busReq, busGrant, busCycle, unitStrobe;
  logic [1:0] unitCh;
  logic [NCH-1:0] extAck, chDone;
  logic grantEn = 1;

  assign busGrant = busReq && grantEn;
  always #(CLK_P/2) clk = ~clk;

  bus_mode_seq uut (
    .clk(clk), .rstN(rstN), .chStart(chStart), .chCount(chCount),
    .chBurst(chBurst), .chExtSrc(chExtSrc), .chUnit(chUnit),
    .extReqN(extReqN), .busReq(busReq), .busGrant(busGrant),
    .busCycle(busCycle), .unitStrobe(unitStrobe), .unitCh(unitCh),
    .extAck(extAck), .chDone(chDone)
  );

  int errors = 0, checks = 0;
  int nCyc, nRise, gapMin, gapMax, lowRun, seqN;
  int nStr [NCH];
  int nDone [NCH];
  int seqLog [64];
  int ackErr = 0, doneErr = 0, grantErr = 0;
  logic sawHigh, prevReq, prevStrobe, clrReq = 0;
  logic [1:0] prevCh;
  logic [NCH-1:0] bExt = '0;

  always begin
    @(posedge clk); #1;
    if (clrReq) begin
      nCyc = 0; nRise = 0; gapMin = 99; gapMax = 0; lowRun = 0; seqN = 0;
      sawHigh = 0; prevReq = busReq; prevStrobe = 0; prevCh = 0;
      for (int c = 0; c < NCH; c++) begin nStr[c] = 0; nDone[c] = 0; end
    end else begin
      if (busCycle) nCyc++;
      if (busCycle && !busGrant) grantErr++;
      if (busReq && !prevReq) nRise++;
      if (busReq) begin
        if (sawHigh && lowRun > 0) begin
          if (lowRun < gapMin) gapMin = lowRun;
          if (lowRun > gapMax) gapMax = lowRun;
        end
        sawHigh = 1; lowRun = 0;
      end else if (sawHigh) lowRun++;
      prevReq = busReq;
      if (unitStrobe) begin
        nStr[unitCh]++;
        if (seqN < 64) begin seqLog[seqN] = int'(unitCh); seqN++; end
      end
      for (int c = 0; c < NCH; c++) begin
        if (extAck[c] != (busCycle && bExt[unitCh] && (c == int'(unitCh)))) ackErr++;
        if (chDone[c]) begin
          nDone[c]++;
          if (!(prevStrobe && int'(prevCh) == c)) doneErr++;
        end
      end
      prevStrobe = unitStrobe; prevCh = unitCh;
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clearStats();
    @(negedge clk); clrReq = 1;
    @(negedge clk); clrReq = 0;
  endtask

  task automatic setCh(input int ch, input int cnt, input logic burst,
                       input logic ext, input logic [1:0] unit);
    chCount[ch*CW +: CW] = CW'(cnt);
    chBurst[ch] = burst; chExtSrc[ch] = ext; chUnit[ch*2 +: 2] = unit;
    chStart[ch] = 1'b1;
    bExt[ch] = ext;
  endtask

  task automatic startCh(input int ch, input int cnt, input logic burst,
                         input logic ext, input logic [1:0] unit);
    @(negedge clk);
    setCh(ch, cnt, burst, ext, unit);
    @(negedge clk); chStart = '0;
  endtask

  task automatic waitDone(input int ch);
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (nDone[ch] > 0) break;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busReq && !busCycle && !unitStrobe && extAck == 0 && chDone == 0,
          "R1 outputs in reset", int'({busReq, busCycle, unitStrobe}), 0);
    rstN = 1;
    clearStats();
    check(!busReq && extAck == 0 && chDone == 0, "R1 idle after reset", int'(busReq), 0);

    for (int v = 0; v < NV; v++) begin
      int ch = v % NCH;
      logic [15:0] e = VEC[v];
      clearStats();
      if (e[14]) extReqN[ch] = 1'b0;
      startCh(ch, int'(e[11:8]), e[15], e[14], e[13:12]);
      waitDone(ch);
      check(nStr[ch] == int'(e[11:8]), "R4 strobe count", nStr[ch], int'(e[11:8]));
      check(nCyc == int'(e[3:0]), "R4 bus cycles", nCyc, int'(e[3:0]));
      check(nRise == int'(e[7:4]), "R6 R7 ownerships", nRise, int'(e[7:4]));
      if (e[7:4] > 1)
        check(gapMin == 1 && gapMax == 1, "R5 one-cycle gap", gapMax, 1);
      check(nDone[ch] == 1, "R11 done pulses", nDone[ch], 1);
      extReqN[ch] = 1'b1;
    end

    // R2 zero count ignored
    clearStats();
    startCh(1, 0, 1'b0, 1'b0, 2'b00);
    repeat (20) @(negedge clk);
    check(nRise == 0 && nDone[1] == 0, "R2 zero count start", nRise, 0);

    // R3 grant withheld
    clearStats();
    grantEn = 0;
    startCh(0, 1, 1'b0, 1'b0, 2'b00);
    repeat (8) @(negedge clk);
    check(busReq == 1'b1, "R3 request held", int'(busReq), 1);
    check(nCyc == 0, "R3 no cycle before grant", nCyc, 0);
    grantEn = 1;
    waitDone(0);
    check(nStr[0] == 1, "R3 transfer after grant", nStr[0], 1);

    // R7 external line inactive
    clearStats();
    startCh(2, 2, 1'b0, 1'b1, 2'b00);
    repeat (20) @(negedge clk);
    check(nRise == 0, "R7 idle while extReqN high", nRise, 0);
    extReqN[2] = 1'b0;
    waitDone(2);
    check(nStr[2] == 2, "R7 transfers while extReqN low", nStr[2], 2);
    extReqN[2] = 1'b1;

    // R9 fixed priority
    clearStats();
    @(negedge clk);
    setCh(3, 2, 1'b0, 1'b0, 2'b00);
    setCh(1, 2, 1'b0, 1'b0, 2'b00);
    @(negedge clk); chStart = '0;
    waitDone(3);
    check(seqN == 4 && seqLog[0] == 1 && seqLog[1] == 1, "R9 low index first", seqLog[0], 1);
    check(seqLog[2] == 3 && seqLog[3] == 3, "R9 high index after", seqLog[2], 3);

    // R8 burst preemption
    clearStats();
    startCh(2, 6, 1'b1, 1'b0, 2'b00);
    for (int k = 0; k < 100; k++) begin
      if (nStr[2] >= 2) break;
      @(negedge clk);
    end
    startCh(0, 1, 1'b0, 1'b0, 2'b00);
    waitDone(2);
    begin
      int pos = -1;
      for (int k = 0; k < seqN; k++) if (seqLog[k] == 0 && pos < 0) pos = k;
      check(pos > 0 && pos < seqN - 1 && seqLog[seqN-1] == 2, "R8 intruder between burst units", pos, 2);
    end
    check(nStr[2] == 6, "R8 burst completes count", nStr[2], 6);
    check(nRise == 3, "R8 ownerships with preemption", nRise, 3);

    // R2 restart while armed ignored
    clearStats();
    startCh(1, 3, 1'b0, 1'b0, 2'b00);
    for (int k = 0; k < 100; k++) begin
      if (nStr[1] >= 1) break;
      @(negedge clk);
    end
    startCh(1, 9, 1'b0, 1'b0, 2'b00);
    waitDone(1);
    repeat (20) @(negedge clk);
    check(nStr[1] == 3, "R2 restart while armed", nStr[1], 3);

    check(ackErr == 0, "R10 extAck cycles", ackErr, 0);
    check(doneErr == 0, "R11 done follows final strobe", doneErr, 0);
    check(grantErr == 0, "R3 cycles only under grant", grantErr, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule